// File: doc/BRIEF.md
# Conditional-execution group state tracker

This block holds the state of a processor's conditional instruction group. In such a group, one prefix instruction makes up to four of the instructions after it conditional. When the prefix is decoded, the pipeline raises a load strobe and supplies an 8-bit field. The upper four bits of the field are the first condition and the lower four bits are a mask. The block checks the field. A legal field becomes the tracker state, and the number of instructions in the group is derived from the position of the lowest set bit of the mask. An illegal field is rejected and reported with an error pulse.

Each time a conditional instruction executes, the pipeline raises an advance strobe. On each advance the counter drops by one and the low five state bits shift left. This shift brings the next instruction's then/else sense into the low bit of the presented condition. After the last instruction the whole state clears.

The outputs are:
- an in-group flag;
- the current 4-bit condition;
- the count of instructions left;
- a one-cycle pulse for a bad encoding;
- a one-cycle pulse for an advance that arrives while no group is open.

The block does not test the condition against the processor flags.

Top module: `cgrp_tracker`

## Requirements
- R1: A legal load sets the remaining count to 4 minus the number of trailing zero bits in mask bits [3:0]. The count is therefore 1 to 4. The full field is stored, so `cond_o` shows field bits [7:4]. Both are visible in the cycle after the load strobe.
- R2: A load whose mask bits [3:0] are all zero is rejected.
- R3: A load whose condition bits [7:4] equal 4'b1111 is rejected.
- R4: A condition of 4'b1110 is accepted only together with mask 4'b1000, which gives a count of 1. Any other mask with that condition is rejected.
- R5: An advance while the count is nonzero decrements the count. When the count reaches zero, the whole state clears, so `cond_o` reads 0.
- R6: When the count stays nonzero after an advance, state bits [4:0] shift left by one and bit 0 fills with zero, while bits [7:5] hold. As a result, `cond_o[0]` takes the previous state bit 3.
- R7: `in_grp_o` is high exactly when `remain_o` is nonzero.
- R8: An advance while the count is zero changes nothing. It raises `misuse_o` for one cycle in the next cycle, and the count never wraps.
- R9: When load and advance arrive in the same cycle, the load wins and the advance is ignored. This also holds when the load is rejected.
- R10: A rejected load leaves the state and the count unchanged. It raises `enc_err_o` for exactly one cycle, in the cycle after the strobe.
- R11: An active-low reset clears the state, the count and both pulse outputs at once, and its release takes effect on the clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| load_i | input | 1 | Prefix decoded; `field_i` is to be checked and taken |
| field_i | input | 8 | Prefix field: [7:4] first condition, [3:0] mask |
| adv_i | input | 1 | One conditional instruction executed |
| in_grp_o | output | 1 | A group is open |
| cond_o | output | 4 | Condition for the current instruction |
| remain_o | output | 3 | Instructions left in the group |
| enc_err_o | output | 1 | One-cycle pulse after a rejected load |
| misuse_o | output | 1 | One-cycle pulse after an advance with no open group |

## Verification
The assertions assume that the strobes are driven only while the synchronized reset is released. They also assume that `field_i` is stable in any cycle where `load_i` is high. They make no assumption about legality: illegal fields and advances with no open group are expected and are checked.

The bench drives inputs on the falling edge and keeps them idle during and for a few cycles after each reset. Its random stimulus draws fields over the full 8-bit range, so all three rejection cases occur alongside legal loads. Advances are frequent enough to reach both the group end and the idle-advance case.

// File: rtl/cgrp_pkg.sv
package cgrp_pkg;

  // Action chosen for the tracker in one cycle
  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,  // nothing, or a rejected load
    ACT_LOAD = 2'd1,  // take a legal field
    ACT_STEP = 2'd2,  // advance inside an open group
    ACT_IDLE = 2'd3   // advance with no open group: ignored
  } cgrp_act_e;

endpackage

// File: rtl/cgrp_decode.sv
module cgrp_decode #(
  parameter int COND_W = 4,
  parameter int MASK_W = 4,
  parameter int CNT_W  = $clog2(MASK_W + 1)
) (
  input  logic [COND_W+MASK_W-1:0] field_i,
  output logic [CNT_W-1:0]         len_o,
  output logic                     bad_o
);

  localparam logic [COND_W-1:0] COND_NEVER  = {COND_W{1'b1}};
  localparam logic [COND_W-1:0] COND_ALWAYS = {COND_W{1'b1}} - 1'b1;
  localparam logic [MASK_W-1:0] MASK_SINGLE = {1'b1, {(MASK_W-1){1'b0}}};
  localparam logic [CNT_W-1:0]  MAX_LEN     = CNT_W'(MASK_W);

  logic [COND_W-1:0] cond;
  logic [MASK_W-1:0] mask;
  logic [CNT_W-1:0]  low_idx;
  logic              found;

  assign cond = field_i[COND_W+MASK_W-1:MASK_W];
  assign mask = field_i[MASK_W-1:0];

  // Locate the lowest set mask bit, i.e. count trailing zeros
  always_comb begin
    found   = 1'b0;
    low_idx = '0;
    for (int i = 0; i < MASK_W; i++) begin
      if (!found && mask[i]) begin
        found   = 1'b1;
        low_idx = CNT_W'(i);
      end
    end
  end

  always_comb begin
    len_o = found ? (MAX_LEN - low_idx) : '0;
    bad_o = !found
          || (cond == COND_NEVER)
          || ((cond == COND_ALWAYS) && (mask != MASK_SINGLE));
  end

  // R4
  always_comb begin
    if ((cond == COND_ALWAYS) && !bad_o) begin
      always_single_chk: assert (len_o == CNT_W'(1));
    end
  end

endmodule

// File: rtl/cgrp_ctrl.sv
module cgrp_ctrl
  import cgrp_pkg::*;
(
  input  logic      load_i,
  input  logic      adv_i,
  input  logic      bad_i,
  input  logic      cnt_zero_i,
  output cgrp_act_e act_o,
  output logic      err_nxt_o,
  output logic      mis_nxt_o
);

  // The load has priority; an advance in the same cycle is dropped
  always_comb begin
    act_o = ACT_HOLD;
    if (load_i) begin
      act_o = bad_i ? ACT_HOLD : ACT_LOAD;
    end else if (adv_i) begin
      act_o = cnt_zero_i ? ACT_IDLE : ACT_STEP;
    end
  end

  always_comb begin
    err_nxt_o = load_i && bad_i;
    mis_nxt_o = (act_o == ACT_IDLE);
  end

endmodule

// File: rtl/cgrp_state.sv
module cgrp_state
  import cgrp_pkg::*;
#(
  parameter int COND_W = 4,
  parameter int MASK_W = 4,
  parameter int CNT_W  = $clog2(MASK_W + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  cgrp_act_e                act_i,
  input  logic [COND_W+MASK_W-1:0] field_i,
  input  logic [CNT_W-1:0]         len_i,
  input  logic                     err_nxt_i,
  input  logic                     mis_nxt_i,
  output logic [COND_W+MASK_W-1:0] st_o,
  output logic [CNT_W-1:0]         cnt_o,
  output logic                     err_o,
  output logic                     mis_o
);

  localparam int ST_W = COND_W + MASK_W;

  logic [ST_W-1:0]  st_q,  st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             err_q, mis_q;
  logic             st_en;

  assign st_en = (act_i == ACT_LOAD) || (act_i == ACT_STEP);

  // Next-state
  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    case (act_i)
      ACT_LOAD: begin
        st_d  = field_i;
        cnt_d = len_i;
      end
      ACT_STEP: begin
        cnt_d = cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) begin
          st_d = '0;
        end else begin
          st_d = {st_q[ST_W-1:MASK_W+1], st_q[MASK_W-1:0], 1'b0};
        end
      end
      default: begin
        st_d  = st_q;
        cnt_d = cnt_q;
      end
    endcase
  end

  // State registers with explicit enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= '0;
      cnt_q <= '0;
    end else if (st_en) begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  // Pulse registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
      mis_q <= 1'b0;
    end else begin
      err_q <= err_nxt_i;
      mis_q <= mis_nxt_i;
    end
  end

  assign st_o  = st_q;
  assign cnt_o = cnt_q;
  assign err_o = err_q;
  assign mis_o = mis_q;

  // R1
  cnt_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(MASK_W));

  // R5
  last_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_i == ACT_STEP && cnt_q == CNT_W'(1)) |=> (st_q == '0 && cnt_q == '0));

  // R6
  shift_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_i == ACT_STEP && cnt_q > CNT_W'(1))
      |=> (st_q[ST_W-1:MASK_W+1] == $past(st_q[ST_W-1:MASK_W+1]) && !st_q[0]));

  // R10
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !err_nxt_i) |=> !err_q);

endmodule

// File: rtl/cgrp_tracker.sv
module cgrp_tracker
  import cgrp_pkg::*;
#(
  parameter int COND_W = 4,
  parameter int MASK_W = 4,
  localparam int FLD_W = COND_W + MASK_W,
  localparam int CNT_W = $clog2(MASK_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [FLD_W-1:0]  field_i,
  input  logic              adv_i,
  output logic              in_grp_o,
  output logic [COND_W-1:0] cond_o,
  output logic [CNT_W-1:0]  remain_o,
  output logic              enc_err_o,
  output logic              misuse_o
);

  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = rst_sync_q[1];

  logic [CNT_W-1:0] len;
  logic             bad;
  cgrp_act_e        act;
  logic             err_nxt, mis_nxt;
  logic [FLD_W-1:0] st;
  logic [CNT_W-1:0] cnt;
  logic             err_q, mis_q;

  cgrp_decode #(.COND_W(COND_W), .MASK_W(MASK_W), .CNT_W(CNT_W)) u_decode (
    .field_i (field_i),
    .len_o   (len),
    .bad_o   (bad)
  );

  cgrp_ctrl u_ctrl (
    .load_i     (load_i),
    .adv_i      (adv_i),
    .bad_i      (bad),
    .cnt_zero_i (cnt == '0),
    .act_o      (act),
    .err_nxt_o  (err_nxt),
    .mis_nxt_o  (mis_nxt)
  );

  cgrp_state #(.COND_W(COND_W), .MASK_W(MASK_W), .CNT_W(CNT_W)) u_state (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .act_i     (act),
    .field_i   (field_i),
    .len_i     (len),
    .err_nxt_i (err_nxt),
    .mis_nxt_i (mis_nxt),
    .st_o      (st),
    .cnt_o     (cnt),
    .err_o     (err_q),
    .mis_o     (mis_q)
  );

  assign in_grp_o  = (cnt != '0);
  assign cond_o    = st[FLD_W-1:MASK_W];
  assign remain_o  = cnt;
  assign enc_err_o = err_q;
  assign misuse_o  = mis_q;

  // R1
  load_len_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (load_i && !bad) |=> (remain_o == $past(len) && cond_o == $past(field_i[FLD_W-1:MASK_W])));

  // R10
  reject_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (load_i && bad) |=> ($stable(st) && $stable(cnt) && enc_err_o));

  // R8
  idle_adv_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (adv_i && !load_i && remain_o == '0) |=> (misuse_o && remain_o == '0));

  // R9
  load_wins_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (load_i && adv_i) |=> !misuse_o);

  // R8
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(enc_err_o && misuse_o));

endmodule

// File: tb/cgrp_tracker_bench.sv
`timescale 1ns/1ps
module cgrp_tracker_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       load_i;
  logic [7:0] field_i;
  logic       adv_i;
  logic       in_grp_o;
  logic [3:0] cond_o;
  logic [2:0] remain_o;
  logic       enc_err_o;
  logic       misuse_o;

  int n_run  = 0;
  int n_fail = 0;
  logic       m_err, m_mis;
  logic [7:0] m_st;
  int         m_cnt;

  always #5 clk = ~clk;

  cgrp_tracker u_cgrp_tracker (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (load_i),
    .field_i   (field_i),
    .adv_i     (adv_i),
    .in_grp_o  (in_grp_o),
    .cond_o    (cond_o),
    .remain_o  (remain_o),
    .enc_err_o (enc_err_o),
    .misuse_o  (misuse_o)
  );

  function automatic int ref_len(input logic [3:0] m);
    if (m[0]) return 4;
    if (m[1]) return 3;
    if (m[2]) return 2;
    if (m[3]) return 1;
    return 0;
  endfunction

  function automatic logic ref_bad(input logic [7:0] f);
    if (f[3:0] == 4'h0) return 1'b1;
    if (f[7:4] == 4'hF) return 1'b1;
    if (f[7:4] == 4'hE && f[3:0] != 4'h8) return 1'b1;
    return 1'b0;
  endfunction

  task automatic chk(input string tg, input string what, input int got, input int exp);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", tg, what, got, exp);
    end
  endtask

  task automatic chk_all(input string tg);
    chk(tg, "remain", int'(remain_o), m_cnt);
    chk(tg, "cond", int'(cond_o), int'(m_st[7:4]));
    chk("R7", "in_grp", int'(in_grp_o), int'(m_cnt != 0));
    chk("R10", "enc_err", int'(enc_err_o), int'(m_err));
    chk("R8", "misuse", int'(misuse_o), int'(m_mis));
  endtask

  // Called on a falling edge; checks on the next falling edge
  task automatic step(input logic ld, input logic [7:0] f, input logic av);
    string tg;
    logic  bad;
    load_i  = ld;
    field_i = f;
    adv_i   = av;
    bad     = ref_bad(f);
    m_err   = ld && bad;
    m_mis   = !ld && av && (m_cnt == 0);
    tg      = "R7";
    if (ld) begin
      if (!bad) begin
        m_st  = f;
        m_cnt = ref_len(f[3:0]);
        tg    = av ? "R9" : "R1";
      end else if (f[3:0] == 4'h0) begin
        tg = "R2";
      end else if (f[7:4] == 4'hF) begin
        tg = "R3";
      end else begin
        tg = "R4";
      end
    end else if (av) begin
      if (m_cnt == 0) begin
        tg = "R8";
      end else begin
        m_cnt--;
        if (m_cnt == 0) begin
          m_st = 8'h00;
          tg   = "R5";
        end else begin
          m_st = {m_st[7:5], m_st[3:0], 1'b0};
          tg   = "R6";
        end
      end
    end
    @(posedge clk);
    @(negedge clk);
    load_i = 1'b0;
    adv_i  = 1'b0;
    chk_all(tg);
  endtask

  task automatic do_reset();
    rst_n  = 1'b0;
    load_i = 1'b0;
    adv_i  = 1'b0;
    field_i = 8'h00;
    #1;
    m_st = 8'h00; m_cnt = 0; m_err = 1'b0; m_mis = 1'b0;
    chk_all("R11");
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk_all("R11");
  endtask

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    @(negedge clk);
    do_reset();

    // Directed corner cases
    step(1'b1, 8'h30, 1'b0);   // R2 zero mask
    step(1'b0, 8'h00, 1'b0);   // R10 pulse drops
    step(1'b1, 8'hF8, 1'b0);   // R3 never-condition
    step(1'b1, 8'hE4, 1'b0);   // R4 always with long mask
    step(1'b1, 8'hE8, 1'b0);   // R4 always, length 1
    step(1'b0, 8'h00, 1'b1);   // R5 group ends
    step(1'b0, 8'h00, 1'b1);   // R8 idle advance
    step(1'b1, 8'h35, 1'b0);   // R1 length 4
    step(1'b1, 8'hF1, 1'b1);   // R9 R10 rejected load with advance: no change
    for (int i = 0; i < 4; i++) step(1'b0, 8'h00, 1'b1);  // R6 then R5
    step(1'b1, 8'h4C, 1'b1);   // R9 load wins, length 2
    step(1'b1, 8'h42, 1'b0);   // R1 reload, length 3
    step(1'b0, 8'h00, 1'b1);   // R6
    do_reset();                // R11 mid-group

    // Random stimulus
    for (int i = 0; i < 3000; i++) begin
      logic ld, av;
      ld = ($urandom_range(0, 3) == 0);
      av = ($urandom_range(0, 9) < 6);
      step(ld, 8'($urandom), av);
      if (i == 1500) do_reset();
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule